// File: doc/BRIEF.md
# Calendar Clock Datapath with Time-of-Day Alarm

This block keeps wall-clock time and calendar date in ten byte-wide registers and moves them forward by one second each time a one-second tick arrives. Seconds, minutes, hours, weekday, day of month, month and two-digit year cascade into each other. The month length follows a fixed table, and February gains a day in years divisible by four. A pair of mode inputs picks the number format, packed decimal (BCD) or plain binary, and the hour style, 24-hour or 12-hour with an afternoon flag. The registers are always kept in the chosen format and are never translated for software.

Software reaches the registers through a simple address/data port. A freeze input holds the clock still while new values are loaded. Each accepted tick opens a one-cycle advance window, flagged on `busy`. When the window closes, the block emits a one-cycle `upd_done` pulse. In that same cycle `alarm_hit` pulses if the freshly advanced seconds, minutes and hours all agree with three alarm registers. An alarm byte whose two top bits are both set matches any value.

Top module: `rtc_calendar_core`

## Requirements
- R1: Register addresses are 0 seconds, 1 seconds-alarm, 2 minutes, 3 minutes-alarm, 4 hours, 5 hours-alarm, 6 weekday, 7 day of month, 8 month, 9 year. `rd_data` shows the addressed register combinationally. A write made while `busy` is low is readable from the next cycle. Addresses 0Ah-0Fh read 00h and ignore writes.
- R2: A tick sampled while `freeze` and `busy` are low raises `busy` for exactly one cycle, starting in the next cycle. The advanced time is readable once `busy` falls. A tick arriving while `busy` is high is dropped.
- R3: `upd_done` pulses high for one cycle, in the cycle right after `busy`.
- R4: While `freeze` is 1, ticks are ignored: `busy` and `upd_done` stay low and the registers keep their values.
- R5: Seconds and minutes run 0-59. With `mode_binary`=0 they hold BCD (59h wraps to 00h, 09h steps to 10h). With `mode_binary`=1 they hold binary (3Bh wraps to 00h, 09h steps to 0Ah).
- R6: With `mode_24h`=1 the hour runs 0-23, and the step from 23 to 0 advances the day.
- R7: With `mode_24h`=0 the hour runs 1-12, and bit 7 set marks afternoon. In BCD, 11h steps to 92h, 92h steps to 81h, and 91h steps to 12h. Only the last of these steps advances the day.
- R8: The weekday runs 1-7 and wraps from 7 to 1 on each day advance.
- R9: The day of month wraps to 1 after 31, 30 or 28 days, depending on the month. February has 29 days when the year is a multiple of 4. Month 12 wraps to 1 and increments the year, and year 99 wraps to 0.
- R10: `alarm_hit` pulses together with `upd_done` when each of the three alarm registers equals its time register after the advance. An alarm register with bits 7 and 6 both set matches any value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-second advance request, one cycle wide |
| freeze | input | 1 | 1 holds time so software can load it |
| mode_binary | input | 1 | 1 selects binary, 0 selects BCD |
| mode_24h | input | 1 | 1 selects 24-hour, 0 selects 12-hour |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the addressed register |
| busy | output | 1 | Advance in progress; time reads are not valid |
| upd_done | output | 1 | One-cycle pulse after each advance |
| alarm_hit | output | 1 | One-cycle alarm match pulse |

## Verification
The hardest case to reach is the full cascade, where a single tick carries from seconds through to the year. It would take years of simulated ticks to get there by counting, so the bench loads 23:59:59 on the last day of a month, or of the year, with freeze set, releases freeze, and sends one tick. The leap-February and 12-hour noon/midnight edges are set up the same way. A back-to-back tick pair checks that a tick landing inside the advance window is dropped.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

   typedef struct packed {
      logic [7:0] sec;
      logic [7:0] min;
      logic [7:0] hr;
      logic [7:0] dow;
      logic [7:0] date;
      logic [7:0] mon;
      logic [7:0] yr;
   } rtc_time_t;

   localparam int NUM_ALARM = 3;

   // field in chosen format -> binary 0..99
   function automatic logic [6:0] fld_dec(input logic [7:0] v, input logic bin);
      if (bin) return v[6:0];
      return 7'(int'(v[7:4]) * 10 + int'(v[3:0]));
   endfunction

   // binary 0..99 -> field in chosen format
   function automatic logic [7:0] fld_enc(input logic [6:0] n, input logic bin);
      if (bin) return {1'b0, n};
      return {4'(n / 7'd10), 4'(n % 7'd10)};
   endfunction

   function automatic logic [6:0] month_days(input logic [6:0] mon, input logic [6:0] yr);
      case (mon)
         7'd2:                       return (yr[1:0] == 2'b00) ? 7'd29 : 7'd28;
         7'd4, 7'd6, 7'd9, 7'd11:    return 7'd30;
         default:                    return 7'd31;
      endcase
   endfunction

endpackage

// File: rtl/rtc_advance.sv
module rtc_advance
   import rtc_cal_pkg::*;
(
   input  rtc_time_t cur,
   input  logic      bin,
   input  logic      h24,
   output rtc_time_t nxt
);
   logic [6:0] s, m, h, h12, d, mo, y, t12;
   logic       c_min, c_hr, c_day, c_mon, c_yr, pm;

   always_comb begin
      s  = fld_dec(cur.sec, bin);
      m  = fld_dec(cur.min, bin);
      d  = fld_dec(cur.date, bin);
      mo = fld_dec(cur.mon, bin);
      y  = fld_dec(cur.yr, bin);
      h12 = fld_dec({1'b0, cur.hr[6:0]}, bin);
      if (h24) h = fld_dec(cur.hr, bin);
      else     h = ((h12 == 7'd12) ? 7'd0 : h12) + (cur.hr[7] ? 7'd12 : 7'd0);

      c_min = (s == 7'd59);
      s     = c_min ? 7'd0 : s + 7'd1;
      c_hr  = c_min && (m == 7'd59);
      if (c_min) m = (m == 7'd59) ? 7'd0 : m + 7'd1;
      c_day = c_hr && (h >= 7'd23);
      if (c_hr) h = (h >= 7'd23) ? 7'd0 : h + 7'd1;
      c_mon = c_day && (d >= month_days(mo, y));
      if (c_day) d = c_mon ? 7'd1 : d + 7'd1;
      c_yr  = c_mon && (mo >= 7'd12);
      if (c_mon) mo = c_yr ? 7'd1 : mo + 7'd1;
      if (c_yr)  y  = (y >= 7'd99) ? 7'd0 : y + 7'd1;

      nxt.sec  = fld_enc(s, bin);
      nxt.min  = fld_enc(m, bin);
      nxt.date = fld_enc(d, bin);
      nxt.mon  = fld_enc(mo, bin);
      nxt.yr   = fld_enc(y, bin);
      nxt.dow  = c_day ? ((cur.dow >= 8'd7) ? 8'd1 : cur.dow + 8'd1) : cur.dow;

      pm  = (h >= 7'd12);
      t12 = pm ? h - 7'd12 : h;
      if (t12 == 7'd0) t12 = 7'd12;
      if (h24) nxt.hr = fld_enc(h, bin);
      else     nxt.hr = fld_enc(t12, bin) | {pm, 7'd0};
   end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
   parameter int NF = 3,
   parameter int W  = 8
) (
   input  logic [NF-1:0][W-1:0] alm,
   input  logic [NF-1:0][W-1:0] val,
   output logic                 hit
);
   logic [NF-1:0] fld_ok;

   for (genvar i = 0; i < NF; i++) begin : g_fld
      assign fld_ok[i] = (alm[i][W-1:W-2] == 2'b11) || (alm[i] == val[i]);
   end

   assign hit = &fld_ok;
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
   import rtc_cal_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              freeze,
   input  logic              mode_binary,
   input  logic              mode_24h,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              busy,
   output logic              upd_done,
   output logic              alarm_hit
);
   localparam int NREG = 10;

   if (DATA_W != 8) begin : g_bad_w
      $error("rtc_calendar_core: DATA_W must be 8");
   end
   if ((1 << ADDR_W) < NREG) begin : g_bad_a
      $error("rtc_calendar_core: ADDR_W too small for register map");
   end

   rtc_time_t                    tm_q, tm_nxt;
   logic [NUM_ALARM-1:0][7:0]    alm_q;
   logic                         busy_q, upd_q, hit_q, hit_nxt;

   rtc_advance u_adv (
      .cur (tm_q),
      .bin (mode_binary),
      .h24 (mode_24h),
      .nxt (tm_nxt)
   );

   rtc_alarm_match #(.NF(NUM_ALARM), .W(8)) u_alm (
      .alm (alm_q),
      .val ({tm_nxt.hr, tm_nxt.min, tm_nxt.sec}),
      .hit (hit_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tm_q   <= '{sec: 8'h00, min: 8'h00, hr: 8'h00, dow: 8'h01,
                     date: 8'h01, mon: 8'h01, yr: 8'h00};
         alm_q  <= '0;
         busy_q <= 1'b0;
         upd_q  <= 1'b0;
         hit_q  <= 1'b0;
      end else begin
         upd_q <= 1'b0;
         hit_q <= 1'b0;
         if (busy_q) begin
            tm_q   <= tm_nxt;
            busy_q <= 1'b0;
            upd_q  <= 1'b1;
            hit_q  <= hit_nxt;
         end else begin
            if (tick && !freeze) busy_q <= 1'b1;
            if (wr_en) begin
               case (addr)
                  ADDR_W'(0): tm_q.sec  <= wr_data;
                  ADDR_W'(1): alm_q[0]  <= wr_data;
                  ADDR_W'(2): tm_q.min  <= wr_data;
                  ADDR_W'(3): alm_q[1]  <= wr_data;
                  ADDR_W'(4): tm_q.hr   <= wr_data;
                  ADDR_W'(5): alm_q[2]  <= wr_data;
                  ADDR_W'(6): tm_q.dow  <= wr_data;
                  ADDR_W'(7): tm_q.date <= wr_data;
                  ADDR_W'(8): tm_q.mon  <= wr_data;
                  ADDR_W'(9): tm_q.yr   <= wr_data;
                  default: ;
               endcase
            end
         end
      end
   end

   always_comb begin
      case (addr)
         ADDR_W'(0): rd_data = tm_q.sec;
         ADDR_W'(1): rd_data = alm_q[0];
         ADDR_W'(2): rd_data = tm_q.min;
         ADDR_W'(3): rd_data = alm_q[1];
         ADDR_W'(4): rd_data = tm_q.hr;
         ADDR_W'(5): rd_data = alm_q[2];
         ADDR_W'(6): rd_data = tm_q.dow;
         ADDR_W'(7): rd_data = tm_q.date;
         ADDR_W'(8): rd_data = tm_q.mon;
         ADDR_W'(9): rd_data = tm_q.yr;
         default:    rd_data = '0;
      endcase
   end

   assign busy      = busy_q;
   assign upd_done  = upd_q;
   assign alarm_hit = hit_q;
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       tick,
   input logic       freeze,
   input logic       wr_en,
   input logic       busy,
   input logic       upd_done,
   input logic       alarm_hit,
   input logic [7:0] sec_q
);
   // R2
   busy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !busy);
   // R2
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !freeze && !busy) |=> busy);
   // R3
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> upd_done);
   // R3
   done_only_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_done |-> $past(busy));
   // R4
   freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze && !busy) |=> !busy);
   // R1
   sec_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !wr_en) |=> $stable(sec_q));
   // R10
   alarm_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_hit |-> upd_done);
endmodule

bind rtc_calendar_core rtc_calendar_chk chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick      (tick),
   .freeze    (freeze),
   .wr_en     (wr_en),
   .busy      (busy),
   .upd_done  (upd_done),
   .alarm_hit (alarm_hit),
   .sec_q     (tm_q.sec)
);

// File: tb/rtc_calendar_core_tb_top.sv
module rtc_calendar_core_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0, freeze = 1'b0, mode_binary = 1'b0, mode_24h = 1'b1;
   logic [3:0] addr = '0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       busy, upd_done, alarm_hit;
   int         n_chk = 0, n_err = 0;

   always #4 clk = ~clk;

   rtc_calendar_core dut_i (
      .clk(clk), .rst_n(rst_n), .tick(tick), .freeze(freeze),
      .mode_binary(mode_binary), .mode_24h(mode_24h), .addr(addr),
      .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .busy(busy), .upd_done(upd_done), .alarm_hit(alarm_hit)
   );

   task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      addr = a; #1 d = rd_data;
   endtask

   task automatic rchk(input string req, input logic [3:0] a, input logic [7:0] exp);
      logic [7:0] v;
      rd(a, v);
      chk(req, $sformatf("reg %0h", a), v, exp);
   endtask

   task automatic set_time(input logic [7:0] s, m, h, dw, dt, mo, y);
      freeze = 1'b1;
      wr(4'h0, s); wr(4'h2, m); wr(4'h4, h); wr(4'h6, dw);
      wr(4'h7, dt); wr(4'h8, mo); wr(4'h9, y);
      freeze = 1'b0;
   endtask

   task automatic tick1(output logic b, output logic u, output logic a);
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0; b = busy;
      @(negedge clk); u = upd_done; a = alarm_hit;
   endtask

   task automatic t_reset;
      rchk("R1", 4'h0, 8'h00); rchk("R1", 4'h6, 8'h01);
      rchk("R1", 4'h7, 8'h01); rchk("R1", 4'h8, 8'h01);
      chk("R2", "busy at reset", 8'(busy), 8'h0);
   endtask

   task automatic t_cascade;
      logic b, u, a;
      set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
      tick1(b, u, a);
      chk("R2", "busy after tick", 8'(b), 8'h1);
      chk("R3", "upd_done after busy", 8'(u), 8'h1);
      rchk("R5", 4'h0, 8'h00); rchk("R5", 4'h2, 8'h00);
      rchk("R6", 4'h4, 8'h00); rchk("R8", 4'h6, 8'h01);
      rchk("R9", 4'h7, 8'h01); rchk("R9", 4'h8, 8'h01);
      rchk("R9", 4'h9, 8'h00);
      @(negedge clk);
      chk("R3", "upd_done one cycle", 8'(upd_done), 8'h0);
   endtask

   task automatic t_formats;
      logic b, u, a;
      set_time(8'h09, 8'h05, 8'h10, 8'h02, 8'h10, 8'h05, 8'h20);
      tick1(b, u, a);
      rchk("R5", 4'h0, 8'h10);
      mode_binary = 1'b1;
      set_time(8'h09, 8'h05, 8'h0A, 8'h02, 8'h0A, 8'h05, 8'h14);
      tick1(b, u, a);
      rchk("R5", 4'h0, 8'h0A);
      set_time(8'h3B, 8'h05, 8'h0A, 8'h02, 8'h0A, 8'h05, 8'h14);
      tick1(b, u, a);
      rchk("R5", 4'h0, 8'h00); rchk("R5", 4'h2, 8'h06);
      mode_binary = 1'b0;
   endtask

   task automatic t_leap;
      logic b, u, a;
      set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24);
      tick1(b, u, a);
      rchk("R9", 4'h7, 8'h29); rchk("R9", 4'h8, 8'h02);
      set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h29, 8'h02, 8'h24);
      tick1(b, u, a);
      rchk("R9", 4'h7, 8'h01); rchk("R9", 4'h8, 8'h03);
      set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h23);
      tick1(b, u, a);
      rchk("R9", 4'h7, 8'h01); rchk("R9", 4'h8, 8'h03);
      set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h30, 8'h04, 8'h23);
      tick1(b, u, a);
      rchk("R9", 4'h7, 8'h01); rchk("R9", 4'h8, 8'h05);
   endtask

   task automatic t_12h;
      logic b, u, a;
      mode_24h = 1'b0;
      set_time(8'h59, 8'h59, 8'h11, 8'h02, 8'h05, 8'h05, 8'h20);
      tick1(b, u, a);
      rchk("R7", 4'h4, 8'h92); rchk("R7", 4'h7, 8'h05);
      set_time(8'h59, 8'h59, 8'h92, 8'h02, 8'h05, 8'h05, 8'h20);
      tick1(b, u, a);
      rchk("R7", 4'h4, 8'h81);
      set_time(8'h59, 8'h59, 8'h91, 8'h02, 8'h05, 8'h05, 8'h20);
      tick1(b, u, a);
      rchk("R7", 4'h4, 8'h12); rchk("R7", 4'h7, 8'h06);
      rchk("R8", 4'h6, 8'h03);
      mode_24h = 1'b1;
   endtask

   task automatic t_freeze;
      set_time(8'h30, 8'h00, 8'h08, 8'h02, 8'h05, 8'h05, 8'h20);
      freeze = 1'b1;
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      chk("R4", "busy while frozen", 8'(busy), 8'h0);
      @(negedge clk);
      chk("R4", "upd_done while frozen", 8'(upd_done), 8'h0);
      rchk("R4", 4'h0, 8'h30);
      freeze = 1'b0;
   endtask

   task automatic t_double_tick;
      set_time(8'h10, 8'h00, 8'h08, 8'h02, 8'h05, 8'h05, 8'h20);
      @(negedge clk); tick = 1'b1;
      @(negedge clk);
      @(negedge clk); tick = 1'b0;
      @(negedge clk);
      chk("R2", "busy after dropped tick", 8'(busy), 8'h0);
      rchk("R2", 4'h0, 8'h11);
   endtask

   task automatic t_alarm;
      logic b, u, a;
      wr(4'h1, 8'h00); wr(4'h3, 8'hC0); wr(4'h5, 8'h10);
      set_time(8'h59, 8'h05, 8'h10, 8'h02, 8'h05, 8'h05, 8'h20);
      tick1(b, u, a);
      chk("R10", "wildcard match", 8'(a), 8'h1);
      tick1(b, u, a);
      chk("R10", "seconds mismatch", 8'(a), 8'h0);
      wr(4'h3, 8'h07); wr(4'h5, 8'h11);
      set_time(8'h59, 8'h06, 8'h10, 8'h02, 8'h05, 8'h05, 8'h20);
      tick1(b, u, a);
      chk("R10", "hour mismatch", 8'(a), 8'h0);
      wr(4'h5, 8'h10);
      set_time(8'h59, 8'h06, 8'h10, 8'h02, 8'h05, 8'h05, 8'h20);
      tick1(b, u, a);
      chk("R10", "exact match", 8'(a), 8'h1);
      rchk("R1", 4'h3, 8'h07); rchk("R1", 4'h5, 8'h10);
   endtask

   task automatic t_unused;
      wr(4'hC, 8'h55);
      rchk("R1", 4'hC, 8'h00);
      rchk("R1", 4'h0, 8'h00);
   endtask

   initial begin
      #(8 * 200000);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_cascade();
      t_formats();
      t_leap();
      t_12h();
      t_freeze();
      t_double_tick();
      t_alarm();
      t_unused();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule